// File: doc/BRIEF.md
# Rendering-Enable Synchronizer with Vertical Scroll Step

This block is a timing slice of a picture processor. A CPU write to the display-mask register turns rendering on or off. The block captures that write and keeps the written enable as a raw flag. It then carries the flag through two non-overlapping half-dot phases, and one more dot-rate stage, before the dot-rate logic acts on it. It keeps its own sub-dot, dot and scanline counters. From the synchronized flag it raises a one-master-clock pulse that steps the vertical scroll at dot 256 of each visible scanline.

A dot lasts four master clocks. The first half of the dot is the right phase and the second half is the left phase. Because the CPU strobe lasts several master clocks, a write may land anywhere inside a dot. The pipeline makes sure that an enable landing late in a line cannot trigger the vertical step on that same line. Downstream logic that needs the enable at once can use the raw flag. Logic that runs at the dot rate uses the synchronized flag.

Top module: `mask_render_sync`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `dot_cnt` and `scan_line` are 0 and `rend_raw`, `rend_sync` and `vinc` are all 0.
- R2: `dot_cnt` advances once every 4 master clocks. It wraps from 340 to 0, and `scan_line` then advances. `scan_line` wraps from the last line of the frame to 0.
- R3: A write is taken on the clock edge where `wr_stb` is sampled low after being high. If `wr_addr` is 1 at that edge, `rend_raw` takes bit 3 of `wr_data` on that edge. While the strobe is still high, `rend_raw` keeps its old value.
- R4: A write whose `wr_addr` is not 1 leaves `rend_raw`, `rend_sync` and `vinc` unchanged.
- R5: `rend_sync` changes only where `dot_cnt` changes, and it is 0 on lines at or above the visible count. Suppose a write lands in sub-dot 0 of dot D. Then `rend_sync` shows the new value from dot D+2. If the write lands in sub-dots 1 to 3, the new value shows from dot D+3.
- R6: `vinc` is high for exactly one master clock, during the first master clock of dot 256 on a visible line. This happens only when the synchronized enable held through dot 255.
- R7: Suppose an enable lands at dot 254, 255, 256 or later, or in sub-dots 1 to 3 of dot 253. Then no `vinc` occurs on that line. If it lands at dot 252 or earlier, or in sub-dot 0 of dot 253, `vinc` occurs on that line. In every case `vinc` occurs on the next visible line.
- R8: A write with bit 3 clear disables rendering. If it lands at dot 100, no `vinc` occurs on that line. If it lands at dot 255, `vinc` still occurs on that line. In both cases no `vinc` occurs on the following line.
- R9: No `vinc` occurs on lines at or above the visible count, even with rendering enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | CPU write strobe; the write is taken on its falling edge |
| wr_addr | input | ADDR_W (3) | Register offset; 1 selects the display mask |
| wr_data | input | DATA_W (8) | Write data; bit 3 is the rendering enable |
| rend_raw | output | 1 | Enable as written, not synchronized |
| rend_sync | output | 1 | Enable after the half-dot pipeline, qualified by the visible region |
| dot_cnt | output | DOT_W (9) | Dot within the scanline, 0 to 340 |
| scan_line | output | LINE_W (9) | Scanline within the frame |
| vinc | output | 1 | Vertical scroll step pulse |

## Verification
The bench places enable writes across the boundary of the dot-256 step: dot 252 at the last sub-dot, both ends of dot 253, and dots 254, 255, 256 and 300 with both strobe widths. A design that acts on the enable one dot too early would step the scroll on a line where a late enable must not reach it. A design that adds a dot too many would miss the step for the write at the start of dot 253. Disables at dot 100 and dot 255 check that the step still uses the enable that held through dot 255. Separate checks cover the sub-dot-dependent latency of `rend_sync`, writes to other offsets being ignored, the raw flag not moving while the strobe is still high, and lines outside the visible region never stepping.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
  // Register offset decoded as the display mask, and the enable bit inside it
  localparam logic [2:0] MASK_REG_OFS = 3'd1;
  localparam int         ENABLE_BIT   = 3;

  // Pipeline stages the enable walks through
  typedef struct packed {
    logic right_ph;  // captured at end of the right half-dot
    logic left_ph;   // passed on at end of the left half-dot
    logic dot_ph;    // visible to dot-rate logic for the following dot
  } sync_stages_t;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dot_timer.sv
module dot_timer #(
  parameter int CLKS_PER_DOT    = 4,
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int SUB_W           = 2,
  parameter int DOT_W           = 9,
  parameter int LINE_W          = 9
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              right_end_o,
  output logic              dot_end_o
);
  localparam logic [SUB_W-1:0]  SUB_LAST   = SUB_W'(CLKS_PER_DOT - 1);
  localparam logic [SUB_W-1:0]  RIGHT_LAST = SUB_W'(CLKS_PER_DOT / 2 - 1);
  localparam logic [DOT_W-1:0]  DOT_LAST   = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(LINES_PER_FRAME - 1);

  logic [SUB_W-1:0] sub_q;

  assign right_end_o = (sub_q == RIGHT_LAST);
  assign dot_end_o   = (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q  <= '0;
      dot_o  <= '0;
      line_o <= '0;
    end else begin
      sub_q <= dot_end_o ? '0 : sub_q + 1'b1;
      if (dot_end_o) begin
        if (dot_o == DOT_LAST) begin
          dot_o  <= '0;
          line_o <= (line_o == LINE_LAST) ? '0 : line_o + 1'b1;
        end else begin
          dot_o <= dot_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mask_capture.sv
module mask_capture #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              raw_o
);
  import rsync_pkg::*;

  localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << ENABLE_BIT;

  logic stb_q;
  logic fall;
  logic hit;

  assign fall = stb_q & ~wr_stb;
  assign hit  = (wr_addr == ADDR_W'(MASK_REG_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      raw_o <= 1'b0;
    end else begin
      stb_q <= wr_stb;
      if (fall && hit) raw_o <= |(wr_data & EN_MASK);
    end
  end
endmodule

// File: rtl/halfdot_sync.sv
module halfdot_sync (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic right_end_i,
  input  logic dot_end_i,
  output logic en_dot_o
);
  import rsync_pkg::*;

  sync_stages_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (right_end_i) st_q.right_ph <= raw_i;
      if (dot_end_i) begin
        st_q.left_ph <= st_q.right_ph;
        st_q.dot_ph  <= st_q.left_ph;
      end
    end
  end

  assign en_dot_o = st_q.dot_ph;
endmodule

// File: rtl/vscroll_inc.sv
module vscroll_inc #(
  parameter int VISIBLE_LINES = 240,
  parameter int VINC_DOT      = 256,
  parameter int DOT_W         = 9,
  parameter int LINE_W        = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_end_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              en_dot_i,
  output logic              vinc_o
);
  localparam logic [DOT_W-1:0]  DOT_BEFORE = DOT_W'(VINC_DOT - 1);
  localparam logic [LINE_W-1:0] VIS_LIM    = LINE_W'(VISIBLE_LINES);

  always_ff @(posedge clk) begin
    if (rst) vinc_o <= 1'b0;
    else     vinc_o <= dot_end_i && (dot_i == DOT_BEFORE) &&
                       (line_i < VIS_LIM) && en_dot_i;
  end
endmodule

// File: rtl/mask_render_sync.sv
module mask_render_sync #(
  parameter int CLKS_PER_DOT    = 4,
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VISIBLE_LINES   = 240,
  parameter int VINC_DOT        = 256,
  parameter int ADDR_W          = 3,
  parameter int DATA_W          = 8,
  localparam int SUB_W  = rsync_pkg::cnt_w(CLKS_PER_DOT),
  localparam int DOT_W  = rsync_pkg::cnt_w(DOTS_PER_LINE),
  localparam int LINE_W = rsync_pkg::cnt_w(LINES_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rend_raw,
  output logic              rend_sync,
  output logic [DOT_W-1:0]  dot_cnt,
  output logic [LINE_W-1:0] scan_line,
  output logic              vinc
);
  localparam logic [LINE_W-1:0] VIS_LIM = LINE_W'(VISIBLE_LINES);

  logic right_end;
  logic dot_end;
  logic en_dot;

  dot_timer #(
    .CLKS_PER_DOT(CLKS_PER_DOT), .DOTS_PER_LINE(DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME), .SUB_W(SUB_W),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_timer (
    .clk(clk), .rst(rst), .dot_o(dot_cnt), .line_o(scan_line),
    .right_end_o(right_end), .dot_end_o(dot_end)
  );

  mask_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .raw_o(rend_raw)
  );

  halfdot_sync u_sync (
    .clk(clk), .rst(rst), .raw_i(rend_raw), .right_end_i(right_end),
    .dot_end_i(dot_end), .en_dot_o(en_dot)
  );

  vscroll_inc #(
    .VISIBLE_LINES(VISIBLE_LINES), .VINC_DOT(VINC_DOT),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_vinc (
    .clk(clk), .rst(rst), .dot_end_i(dot_end), .dot_i(dot_cnt),
    .line_i(scan_line), .en_dot_i(en_dot), .vinc_o(vinc)
  );

  assign rend_sync = en_dot && (scan_line < VIS_LIM);
endmodule

// File: rtl/mask_render_sync_chk.sv
module mask_render_sync_chk #(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VISIBLE_LINES   = 240,
  parameter int VINC_DOT        = 256,
  parameter int ADDR_W          = 3,
  parameter int DOT_W           = 9,
  parameter int LINE_W          = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rend_raw,
  input logic              rend_sync,
  input logic [DOT_W-1:0]  dot_cnt,
  input logic [LINE_W-1:0] scan_line,
  input logic              vinc
);
  import rsync_pkg::*;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (dot_cnt < DOT_W'(DOTS_PER_LINE)) && (scan_line < LINE_W'(LINES_PER_FRAME))); // R2

  AST_RAW_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (rend_raw != $past(rend_raw)) |->
      ($past(wr_stb, 2) && !$past(wr_stb) && ($past(wr_addr) == ADDR_W'(MASK_REG_OFS)))); // R3

  AST_SYNC_ON_DOT: assert property (@(posedge clk) disable iff (rst)
    !$stable(rend_sync) |-> !$stable(dot_cnt)); // R5

  AST_SYNC_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    rend_sync |-> (scan_line < LINE_W'(VISIBLE_LINES))); // R5

  AST_VINC_POSITION: assert property (@(posedge clk) disable iff (rst)
    vinc |-> (dot_cnt == DOT_W'(VINC_DOT)) && (scan_line < LINE_W'(VISIBLE_LINES))); // R6

  AST_VINC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vinc |=> !vinc); // R6

  AST_VINC_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    vinc |-> $past(rend_sync)); // R6
endmodule

bind mask_render_sync mask_render_sync_chk #(
  .DOTS_PER_LINE(DOTS_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
  .VISIBLE_LINES(VISIBLE_LINES), .VINC_DOT(VINC_DOT),
  .ADDR_W(ADDR_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
) u_chk (.*);

// File: tb/test_mask_render_sync.sv
module test_mask_render_sync;
  localparam int LINES  = 6;
  localparam int VIS    = 4;
  localparam int DOT_W  = rsync_pkg::cnt_w(341);
  localparam int LINE_W = rsync_pkg::cnt_w(LINES);

  // pre, dot, sub-dot, strobe width, data, vinc this line, vinc next line
  localparam int VEC [11][7] = '{
    '{8'h00, 252, 3, 9, 8'h08, 1, 1},
    '{8'h00, 253, 0, 8, 8'h08, 1, 1},
    '{8'h00, 253, 3, 9, 8'h08, 0, 1},
    '{8'h00, 254, 0, 8, 8'h08, 0, 1},
    '{8'h00, 254, 2, 9, 8'h08, 0, 1},
    '{8'h00, 255, 0, 8, 8'h08, 0, 1},
    '{8'h00, 256, 0, 8, 8'h08, 0, 1},
    '{8'h00, 300, 1, 8, 8'h08, 0, 1},
    '{8'h08, 100, 0, 8, 8'hF7, 0, 0},
    '{8'h08, 255, 0, 8, 8'h00, 1, 0},
    '{8'h00, 200, 0, 8, 8'hFF, 1, 1}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_stb = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              rend_raw, rend_sync, vinc;
  logic [DOT_W-1:0]  dot_cnt;
  logic [LINE_W-1:0] scan_line;

  int n_chk = 0;
  int n_bad = 0;
  int vcnt [LINES];

  always #10 clk = ~clk;

  mask_render_sync #(.LINES_PER_FRAME(LINES), .VISIBLE_LINES(VIS)) i_mask_render_sync (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rend_raw(rend_raw), .rend_sync(rend_sync), .dot_cnt(dot_cnt),
    .scan_line(scan_line), .vinc(vinc)
  );

  always @(negedge clk) if (!rst && vinc) vcnt[scan_line] = vcnt[scan_line] + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_pos(input int ln, input int d);
    do @(negedge clk); while (!(int'(scan_line) == ln && int'(dot_cnt) == d));
  endtask

  task automatic clear_cnt();
    @(posedge clk);
    for (int l = 0; l < LINES; l++) vcnt[l] = 0;
  endtask

  // Strobe falls so that the capturing edge closes sub-dot m of dot d
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input int ln,
                    input int dt, input int m, input int w, input string tag);
    logic old;
    wait_pos(ln, dt - 3);
    for (int k = 0; k <= 12 + m; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 12 + m - w) begin wr_stb = 1'b1; wr_addr = a; wr_data = d; end
      if (k == 12 + m) wr_stb = 1'b0;
    end
    old = rend_raw;
    @(negedge clk);
    chk({tag, " raw after write"}, int'(rend_raw), (a == 3'd1) ? int'(d[3]) : int'(old));
    wr_addr = '0;
    wr_data = '0;
  endtask

  // First dot at which rend_sync shows the new value
  task automatic lat(input int dx, input int expv, input string tag);
    logic p;
    do begin p = rend_sync; @(negedge clk); end while (int'(dot_cnt) != dx);
    chk({tag, " sync before"}, int'(p), 1 - expv);
    chk({tag, " sync at"}, int'(rend_sync), expv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    for (int l = 0; l < LINES; l++) vcnt[l] = 0;
    repeat (5) @(negedge clk);
    chk("R1 dot", int'(dot_cnt), 0);
    chk("R1 line", int'(scan_line), 0);
    chk("R1 raw", int'(rend_raw), 0);
    chk("R1 sync", int'(rend_sync), 0);
    chk("R1 vinc", int'(vinc), 0);
    rst = 1'b0;
    c = 0;
    do begin @(negedge clk); c++; end while (dot_cnt == '0);
    chk("R2 clocks per dot", c, 4);
    chk("R2 first dot", int'(dot_cnt), 1);

    // R4: other offsets ignored
    wr(3'd0, 8'hFF, 0, 50, 0, 8, "R4 offset0");
    wr(3'd2, 8'h08, 0, 120, 0, 8, "R4 offset2");
    clear_cnt();
    wait_pos(2, 0);
    @(posedge clk);
    chk("R4 no vinc", vcnt[1], 0);
    chk("R4 no sync", int'(rend_sync), 0);

    // R3 capture on fall, R5 latency from sub-dot 0
    wait_pos(2, 80);
    wr_stb = 1'b1; wr_addr = 3'd1; wr_data = 8'h08;
    repeat (4) @(negedge clk);
    chk("R3 raw while strobe high", int'(rend_raw), 0);
    wr_stb = 1'b0;
    @(negedge clk);
    chk("R3 raw after fall", int'(rend_raw), 1);
    wr_addr = '0; wr_data = '0;
    wr(3'd1, 8'h00, 3, 10, 0, 8, "R3 off");
    wr(3'd1, 8'h08, 3, 100, 0, 8, "R3 on");
    lat(102, 1, "R5 sub0");

    // R6 and R9 over a full frame with rendering on
    wait_pos(0, 0);
    clear_cnt();
    wait_pos(LINES - 1, 300);
    chk("R9 sync off-screen", int'(rend_sync), 0);
    wait_pos(0, 0);
    @(posedge clk);
    for (int l = 0; l < LINES; l++)
      chk((l < VIS) ? "R6 vinc visible line" : "R9 vinc off-screen line", vcnt[l], (l < VIS) ? 1 : 0);

    // R5 latency from sub-dot 1
    wr(3'd1, 8'h00, 1, 100, 1, 8, "R5 off");
    lat(103, 0, "R5 sub1 off");
    wr(3'd1, 8'h08, 2, 100, 1, 9, "R5 on");
    lat(103, 1, "R5 sub1 on");

    // R2 frame wrap
    wait_pos(LINES - 1, 340);
    c = 0;
    do begin @(negedge clk); c++; end while (int'(dot_cnt) == 340);
    chk("R2 wrap dot", int'(dot_cnt), 0);
    chk("R2 wrap line", int'(scan_line), 0);
    chk("R2 wrap clocks", c, 4);

    // R7 / R8 vector table
    for (int i = 0; i < 11; i++) begin
      string tg;
      tg = (i == 8 || i == 9) ? "R8" : "R7";
      wr(3'd1, 8'(VEC[i][0]), 0, 20, 0, 8, {tg, " pre"});
      clear_cnt();
      wr(3'd1, 8'(VEC[i][4]), 1, VEC[i][1], VEC[i][2], VEC[i][3], tg);
      wait_pos(3, 0);
      @(posedge clk);
      chk({tg, " vinc same line"}, vcnt[1], VEC[i][5]);
      chk({tg, " vinc next line"}, vcnt[2], VEC[i][6]);
    end

    finish_run();
  end
endmodule